// File: doc/BRIEF.md
# Programmable Parallel Bus Master

This block turns a simple internal read/write request into a complete cycle on an external NOR-style parallel bus. A transaction moves through a fixed sequence of phases. First comes a setup delay with every chip select idle. Next is an address phase with the address-valid strobe and, optionally, the address placed on the data pins. Then comes a write or output-enable strobe. Last is a hold phase in which the chip select is still asserted. Each phase length is a programmed field value N, which lasts N+1 clock cycles.

Every configuration input is static. The configuration selects a 16-bit or full-width data path, multiplexed address/data, and an independent active-high option for the ready, address-valid, strobe and chip-select lines. It also picks which of the chip-select outputs the transaction drives. An optional wait mode holds the strobe until a minimum count has expired and the device reports ready. A second option tells the block that ready leads valid data by one cycle. Completion is a one-cycle pulse. Read data is held on the response port until the next read.

Top module: `pbus_master`

## Requirements
- R1: `req_ready` is high exactly when the block is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Requests presented while busy have no effect on the address, data or direction of the transaction in progress.
- R2: After acceptance, all chip selects stay inactive for `cfg_setup_len`+1 cycles. The address phase follows, with address-valid active for its first `cfg_adv_len`+1 cycles. With all fields at 0, a transaction takes 4 cycles from acceptance to the done pulse.
- R3: When `cfg_mux`=1, the address drives the data pins with `bus_doe`=1 for `cfg_mux_len`+1 cycles, and the address phase lasts max(`cfg_adv_len`,`cfg_mux_len`)+1 cycles. When `cfg_mux`=0, the data pins are not driven during the address phase.
- R4: Without wait mode, a write asserts the write strobe for `cfg_we_len`+1 cycles, with `bus_doe`=1 and the write data on `bus_dout`.
- R5: Without wait mode, a read asserts the output-enable strobe for `cfg_oe_len`+1 cycles, with `bus_doe`=0. The data pins are sampled in the last strobe cycle.
- R6: After the strobe ends, the selected chip select stays active for `cfg_hold_len`+1 further cycles. The block then returns to idle.
- R7: With `cfg_wait_en`=1 and `cfg_rdy_early`=0, the strobe lasts until at least `cfg_wait_len`+1 strobe cycles have elapsed and ready is seen. The strobe ends, and read data is sampled, in the cycle where ready is seen. Ready seen earlier than that is ignored.
- R8: With `cfg_wait_en`=1 and `cfg_rdy_early`=1, the strobe ends, and read data is sampled, one cycle after the qualifying ready cycle.
- R9: A polarity bit of 0 makes its line active low, and a bit of 1 makes it active high. The bits are `cfg_rdy_hi` (ready input), `cfg_adv_hi` (address valid), `cfg_strb_hi` (both the write strobe and the output-enable strobe) and `cfg_cs_hi` (all chip selects). Lines rest at their inactive level when idle.
- R10: Only `bus_cs[cfg_cs_sel]` is ever asserted. All other chip-select outputs stay at their inactive level.
- R11: When `cfg_wide`=0, only the low half of the data bus carries data. The upper half of `bus_dout` is driven to 0, and the upper half of `rsp_rdata` reads 0. When `cfg_wide`=1, the full width is used.
- R12: `rsp_done` is a single-cycle pulse in the first idle cycle after the hold phase. For a read, `rsp_rdata` holds the sampled data from that cycle until the next read completes.
- R13: During and right after reset, the block is idle (`req_ready`=1). `rsp_done`=0, `bus_doe`=0, and every control output is at its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Transfer address |
| req_wdata | input | DW | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Last read result |
| cfg_wide | input | 1 | 1 = full data width, 0 = low half |
| cfg_mux | input | 1 | Address on data pins during address phase |
| cfg_wait_en | input | 1 | Strobe end governed by ready |
| cfg_rdy_early | input | 1 | Ready leads data by one cycle |
| cfg_rdy_hi | input | 1 | Ready input active high |
| cfg_adv_hi | input | 1 | Address-valid output active high |
| cfg_strb_hi | input | 1 | Write and output-enable strobes active high |
| cfg_cs_hi | input | 1 | Chip selects active high |
| cfg_cs_sel | input | CSW | Index of the chip select to use |
| cfg_setup_len | input | 4 | Setup cycles minus one |
| cfg_adv_len | input | 4 | Address-valid cycles minus one |
| cfg_mux_len | input | 4 | Multiplexed address cycles minus one |
| cfg_we_len | input | 4 | Write strobe cycles minus one |
| cfg_hold_len | input | 4 | Hold cycles minus one |
| cfg_oe_len | input | 8 | Output-enable cycles minus one |
| cfg_wait_len | input | 8 | Minimum strobe cycles before ready, minus one |
| bus_addr | output | AW | External address |
| bus_dout | output | DW | Data pins, outgoing value |
| bus_din | input | DW | Data pins, incoming value |
| bus_doe | output | 1 | Drive enable for the data pins |
| bus_cs | output | NCS | Chip-select outputs |
| bus_adv | output | 1 | Address-valid strobe |
| bus_we | output | 1 | Write strobe |
| bus_oe | output | 1 | Output-enable strobe |
| bus_rdy | input | 1 | Ready from the external device |

## Verification
The hardest case to reach is the exact sampling cycle in wait mode. The outcome depends on where the device's ready falls relative to the expiry of the wait count, and on whether ready leads the data. The bench models the device so that it raises ready a programmed number of strobe cycles in and drives a poison value until its data is valid. Sweeping that delay to both sides of the wait count, in both early and coincident modes, makes any sampling one cycle off show up as a wrong read value and a wrong strobe length.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    localparam int SHORT_W = 4;
    localparam int LONG_W  = 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_ADDR,
        PH_STRB,
        PH_HOLD
    } phase_e;

    typedef struct packed {
        logic               mux;
        logic               wait_en;
        logic               rdy_early;
        logic [SHORT_W-1:0] setup_len;
        logic [SHORT_W-1:0] adv_len;
        logic [SHORT_W-1:0] mux_len;
        logic [SHORT_W-1:0] we_len;
        logic [SHORT_W-1:0] hold_len;
        logic [LONG_W-1:0]  oe_len;
        logic [LONG_W-1:0]  wait_len;
    } timing_t;

    // Last counter value of the address phase.
    function automatic logic [LONG_W-1:0] addr_last(timing_t t);
        logic [SHORT_W-1:0] m;
        m = (t.mux && (t.mux_len > t.adv_len)) ? t.mux_len : t.adv_len;
        return LONG_W'(m);
    endfunction

    // Pin level for an internal active flag under a polarity bit.
    function automatic logic pin_level(logic active, logic act_hi);
        return act_hi ? active : ~active;
    endfunction

endpackage

// File: rtl/pbus_seq.sv
module pbus_seq
    import pbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              wr,
    input  timing_t           tcfg,
    input  logic              rdy_act,
    output phase_e            phase,
    output logic [LONG_W-1:0] cnt,
    output logic              strb_last,
    output logic              done
);

    logic              pend;
    logic              wait_met;
    logic              setup_end;
    logic              addr_end;
    logic              hold_end;
    logic [LONG_W-1:0] strb_len;

    always_comb begin
        setup_end = (cnt == LONG_W'(tcfg.setup_len));
        addr_end  = (cnt == addr_last(tcfg));
        hold_end  = (cnt == LONG_W'(tcfg.hold_len));
        strb_len  = wr ? LONG_W'(tcfg.we_len) : tcfg.oe_len;
        wait_met  = (cnt >= tcfg.wait_len);
        if (phase != PH_STRB)    strb_last = 1'b0;
        else if (!tcfg.wait_en)  strb_last = (cnt == strb_len);
        else if (tcfg.rdy_early) strb_last = pend;
        else                     strb_last = wait_met && rdy_act;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            pend  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (cnt != '1) cnt <= cnt + 1'b1;
            unique case (phase)
                PH_IDLE: begin
                    cnt <= '0;
                    if (start) phase <= PH_SETUP;
                end
                PH_SETUP: if (setup_end) begin
                    phase <= PH_ADDR;
                    cnt   <= '0;
                end
                PH_ADDR: if (addr_end) begin
                    phase <= PH_STRB;
                    cnt   <= '0;
                end
                PH_STRB: begin
                    if (tcfg.wait_en && tcfg.rdy_early && wait_met && rdy_act)
                        pend <= 1'b1;
                    if (strb_last) begin
                        phase <= PH_HOLD;
                        cnt   <= '0;
                        pend  <= 1'b0;
                    end
                end
                PH_HOLD: if (hold_end) begin
                    phase <= PH_IDLE;
                    cnt   <= '0;
                    done  <= 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Strobe may not end before the minimum wait count has elapsed.
    assert_wait_gate_R7: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_STRB && tcfg.wait_en && cnt < tcfg.wait_len) |=> (phase == PH_STRB));

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/pbus_pins.sv
module pbus_pins
    import pbus_pkg::*;
#(
    parameter int AW  = 24,
    parameter int DW  = 32,
    parameter int NCS = 8,
    localparam int CSW  = $clog2(NCS),
    localparam int HALF = DW / 2
) (
    input  logic              clk,
    input  logic              rst,
    input  phase_e            phase,
    input  logic [LONG_W-1:0] cnt,
    input  timing_t           tcfg,
    input  logic              wide,
    input  logic              wr,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    input  logic [CSW-1:0]    cs_sel,
    input  logic              adv_hi,
    input  logic              strb_hi,
    input  logic              cs_hi,
    output logic [DW-1:0]     dout,
    output logic              doe,
    output logic [NCS-1:0]    cs_pin,
    output logic              adv_pin,
    output logic              we_pin,
    output logic              oe_pin
);

    logic [DW-1:0]  mask;
    logic [DW-1:0]  addr_on_data;
    logic [NCS-1:0] cs_act;
    logic           cs_on, adv_on, mux_on, we_on, oe_on;

    generate
        if (AW >= DW) begin : g_addr_trunc
            assign addr_on_data = addr[DW-1:0];
        end else begin : g_addr_ext
            assign addr_on_data = {{(DW-AW){1'b0}}, addr};
        end
    endgenerate

    always_comb begin
        mask   = wide ? '1 : {{(DW-HALF){1'b0}}, {HALF{1'b1}}};
        cs_on  = (phase == PH_ADDR) || (phase == PH_STRB) || (phase == PH_HOLD);
        adv_on = (phase == PH_ADDR) && (cnt <= LONG_W'(tcfg.adv_len));
        mux_on = (phase == PH_ADDR) && tcfg.mux && (cnt <= LONG_W'(tcfg.mux_len));
        we_on  = (phase == PH_STRB) && wr;
        oe_on  = (phase == PH_STRB) && !wr;
        doe    = mux_on || we_on;
        if (mux_on)     dout = addr_on_data & mask;
        else if (we_on) dout = wdata & mask;
        else            dout = '0;
        adv_pin = pin_level(adv_on, adv_hi);
        we_pin  = pin_level(we_on, strb_hi);
        oe_pin  = pin_level(oe_on, strb_hi);
    end

    generate
        for (genvar i = 0; i < NCS; i++) begin : g_cs
            assign cs_act[i] = cs_on && (cs_sel == CSW'(i));
            assign cs_pin[i] = pin_level(cs_act[i], cs_hi);
        end
    endgenerate

    assert_cs_single_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cs_act));

    assert_read_no_drive_R5: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_STRB && !wr) |-> !doe);

endmodule

// File: rtl/pbus_capture.sv
module pbus_capture #(
    parameter int DW = 32,
    localparam int HALF = DW / 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cap_en,
    input  logic          wide,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mask;
    assign mask = wide ? '1 : {{(DW-HALF){1'b0}}, {HALF{1'b1}}};

    always_ff @(posedge clk) begin
        if (rst)         rdata <= '0;
        else if (cap_en) rdata <= din & mask;
    end

endmodule

// File: rtl/pbus_master.sv
module pbus_master
    import pbus_pkg::*;
#(
    parameter int AW  = 24,
    parameter int DW  = 32,
    parameter int NCS = 8,
    localparam int CSW = $clog2(NCS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [AW-1:0]      req_addr,
    input  logic [DW-1:0]      req_wdata,
    output logic               rsp_done,
    output logic [DW-1:0]      rsp_rdata,
    input  logic               cfg_wide,
    input  logic               cfg_mux,
    input  logic               cfg_wait_en,
    input  logic               cfg_rdy_early,
    input  logic               cfg_rdy_hi,
    input  logic               cfg_adv_hi,
    input  logic               cfg_strb_hi,
    input  logic               cfg_cs_hi,
    input  logic [CSW-1:0]     cfg_cs_sel,
    input  logic [SHORT_W-1:0] cfg_setup_len,
    input  logic [SHORT_W-1:0] cfg_adv_len,
    input  logic [SHORT_W-1:0] cfg_mux_len,
    input  logic [SHORT_W-1:0] cfg_we_len,
    input  logic [SHORT_W-1:0] cfg_hold_len,
    input  logic [LONG_W-1:0]  cfg_oe_len,
    input  logic [LONG_W-1:0]  cfg_wait_len,
    output logic [AW-1:0]      bus_addr,
    output logic [DW-1:0]      bus_dout,
    input  logic [DW-1:0]      bus_din,
    output logic               bus_doe,
    output logic [NCS-1:0]     bus_cs,
    output logic               bus_adv,
    output logic               bus_we,
    output logic               bus_oe,
    input  logic               bus_rdy
);

    timing_t           tcfg;
    phase_e            phase;
    logic [LONG_W-1:0] cnt;
    logic              strb_last;
    logic              start;
    logic              rdy_act;
    logic              wr_q;
    logic [AW-1:0]     addr_q;
    logic [DW-1:0]     wdata_q;

    always_comb begin
        tcfg.mux       = cfg_mux;
        tcfg.wait_en   = cfg_wait_en;
        tcfg.rdy_early = cfg_rdy_early;
        tcfg.setup_len = cfg_setup_len;
        tcfg.adv_len   = cfg_adv_len;
        tcfg.mux_len   = cfg_mux_len;
        tcfg.we_len    = cfg_we_len;
        tcfg.hold_len  = cfg_hold_len;
        tcfg.oe_len    = cfg_oe_len;
        tcfg.wait_len  = cfg_wait_len;
    end

    assign req_ready = (phase == PH_IDLE);
    assign start     = req_valid && req_ready;
    assign rdy_act   = cfg_rdy_hi ? bus_rdy : ~bus_rdy;
    assign bus_addr  = addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (start) begin
            wr_q    <= req_write;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    pbus_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .wr        (wr_q),
        .tcfg      (tcfg),
        .rdy_act   (rdy_act),
        .phase     (phase),
        .cnt       (cnt),
        .strb_last (strb_last),
        .done      (rsp_done)
    );

    pbus_pins #(.AW(AW), .DW(DW), .NCS(NCS)) u_pins (
        .clk     (clk),
        .rst     (rst),
        .phase   (phase),
        .cnt     (cnt),
        .tcfg    (tcfg),
        .wide    (cfg_wide),
        .wr      (wr_q),
        .addr    (addr_q),
        .wdata   (wdata_q),
        .cs_sel  (cfg_cs_sel),
        .adv_hi  (cfg_adv_hi),
        .strb_hi (cfg_strb_hi),
        .cs_hi   (cfg_cs_hi),
        .dout    (bus_dout),
        .doe     (bus_doe),
        .cs_pin  (bus_cs),
        .adv_pin (bus_adv),
        .we_pin  (bus_we),
        .oe_pin  (bus_oe)
    );

    pbus_capture #(.DW(DW)) u_cap (
        .clk    (clk),
        .rst    (rst),
        .cap_en (strb_last && !wr_q),
        .wide   (cfg_wide),
        .din    (bus_din),
        .rdata  (rsp_rdata)
    );

    // Port-level views used by the checks below.
    logic strb_pin_act;
    logic cs_any_act;
    assign strb_pin_act = cfg_strb_hi ? (bus_we | bus_oe) : ~(bus_we & bus_oe);
    assign cs_any_act   = cfg_cs_hi ? (|bus_cs) : ~(&bus_cs);

    assert_busy_ignore_R1: assert property (@(posedge clk) disable iff (rst)
        !req_ready |=> ($stable(bus_addr) && $stable(wr_q)));

    assert_cs_quiet_setup_R2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SETUP) |-> !cs_any_act);

    assert_hold_after_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(strb_pin_act) |-> cs_any_act);

endmodule

// File: tb/pbus_master_bench.sv
module pbus_master_bench;

    localparam int AW  = 24;
    localparam int DW  = 32;
    localparam int NCS = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst;
    logic          req_valid, req_ready, req_write, rsp_done;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata, rsp_rdata;
    logic          cfg_wide, cfg_mux, cfg_wait_en, cfg_rdy_early;
    logic          cfg_rdy_hi, cfg_adv_hi, cfg_strb_hi, cfg_cs_hi;
    logic [2:0]    cfg_cs_sel;
    logic [3:0]    cfg_setup_len, cfg_adv_len, cfg_mux_len, cfg_we_len, cfg_hold_len;
    logic [7:0]    cfg_oe_len, cfg_wait_len;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_dout, bus_din;
    logic          bus_doe, bus_adv, bus_we, bus_oe, bus_rdy;
    logic [NCS-1:0] bus_cs;

    pbus_master #(.AW(AW), .DW(DW), .NCS(NCS)) u_pbus_master (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .cfg_wide(cfg_wide),
        .cfg_mux(cfg_mux), .cfg_wait_en(cfg_wait_en), .cfg_rdy_early(cfg_rdy_early),
        .cfg_rdy_hi(cfg_rdy_hi), .cfg_adv_hi(cfg_adv_hi), .cfg_strb_hi(cfg_strb_hi),
        .cfg_cs_hi(cfg_cs_hi), .cfg_cs_sel(cfg_cs_sel), .cfg_setup_len(cfg_setup_len),
        .cfg_adv_len(cfg_adv_len), .cfg_mux_len(cfg_mux_len), .cfg_we_len(cfg_we_len),
        .cfg_hold_len(cfg_hold_len), .cfg_oe_len(cfg_oe_len), .cfg_wait_len(cfg_wait_len),
        .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_din(bus_din), .bus_doe(bus_doe),
        .bus_cs(bus_cs), .bus_adv(bus_adv), .bus_we(bus_we), .bus_oe(bus_oe),
        .bus_rdy(bus_rdy)
    );

    int nchk = 0;
    int nerr = 0;
    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    function automatic logic [31:0] pat(logic [AW-1:0] a);
        return {a[7:0] ^ 8'hA5, a};
    endfunction

    function automatic logic [31:0] wmask();
        return cfg_wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    endfunction

    // External device model: raises ready dev_delay strobe cycles in,
    // drives a poison value until its data is valid.
    logic oe_b, we_b, adv_b;
    logic [8:0] oe_cnt = '0;
    int dev_delay = 0;
    logic dev_rdy, dev_valid;
    assign oe_b  = cfg_strb_hi ? bus_oe : ~bus_oe;
    assign we_b  = cfg_strb_hi ? bus_we : ~bus_we;
    assign adv_b = cfg_adv_hi ? bus_adv : ~bus_adv;
    always @(posedge clk) oe_cnt <= oe_b ? oe_cnt + 9'd1 : 9'd0;
    assign dev_rdy   = oe_b && (int'(oe_cnt) >= dev_delay);
    assign dev_valid = oe_b && (!cfg_wait_en ||
                       (int'(oe_cnt) >= dev_delay + (cfg_rdy_early ? 1 : 0)));
    assign bus_din = dev_valid ? pat(bus_addr) : 32'hDEAD_BEEF;
    assign bus_rdy = cfg_rdy_hi ? dev_rdy : ~dev_rdy;

    typedef struct {
        string       tag;
        bit          rd;
        logic [31:0] rdata;
        int          lat, adv, cs, strb, mux;
        longint      start;
    } exp_t;
    exp_t q[$];

    bit inflight = 0;
    int m_cs, m_adv, m_strb, m_we, m_mux, m_bad, m_wrongcs;
    logic [AW-1:0] m_addr;
    logic [31:0]   m_wdata;

    function automatic bit cs_act(int i);
        return cfg_cs_hi ? bus_cs[i] : ~bus_cs[i];
    endfunction

    // Monitor: collects pin activity and compares on each done pulse.
    always @(negedge clk) begin
        if (!rst && rsp_done && !inflight) chk("R12 stray done", 1, 0);
        if (inflight) begin
            for (int i = 0; i < NCS; i++)
                if (cs_act(i)) begin
                    if (i == int'(cfg_cs_sel)) m_cs++;
                    else m_wrongcs++;
                end
            if (adv_b) m_adv++;
            if (oe_b || we_b) m_strb++;
            if (we_b) m_we++;
            if (cs_act(int'(cfg_cs_sel)) && bus_addr !== m_addr) m_bad++;
            if (!(oe_b || we_b) && bus_doe) begin
                m_mux++;
                if (bus_dout !== ({8'h00, m_addr} & wmask())) m_bad++;
            end
            if (we_b && (!bus_doe || bus_dout !== (m_wdata & wmask()))) m_bad++;
            if (oe_b && bus_doe) m_bad++;
            if (rsp_done) begin
                exp_t e;
                e = q.pop_front();
                chk({e.tag, " latency"}, 64'(cyc - e.start), 64'(e.lat));
                chk("R2 adv cycles", 64'(m_adv), 64'(e.adv));
                chk("R3 mux cycles", 64'(m_mux), 64'(e.mux));
                chk({e.tag, " strobe cycles"}, 64'(m_strb), 64'(e.strb));
                chk("R1 direction kept", 64'(m_we), e.rd ? 64'd0 : 64'(e.strb));
                chk("R6 cs cycles", 64'(m_cs), 64'(e.cs));
                chk("R10 other cs", 64'(m_wrongcs), 64'd0);
                chk("R4 pin data", 64'(m_bad), 64'd0);
                if (e.rd) chk({e.tag, " rdata"}, 64'(rsp_rdata), 64'(e.rdata));
                chk("R9 idle levels", 64'({bus_cs, bus_adv, bus_we, bus_oe}),
                    64'({{NCS{~cfg_cs_hi}}, ~cfg_adv_hi, ~cfg_strb_hi, ~cfg_strb_hi}));
                inflight = 0;
            end
        end
    end

    task automatic xfer(string tag, bit rd, logic [AW-1:0] a, logic [31:0] d, bit poke);
        exp_t e;
        int k, t, al;
        al = (cfg_mux && cfg_mux_len > cfg_adv_len) ? int'(cfg_mux_len) : int'(cfg_adv_len);
        k = (int'(cfg_wait_len) > dev_delay) ? int'(cfg_wait_len) : dev_delay;
        if (!rd)              t = int'(cfg_we_len) + 1;
        else if (!cfg_wait_en) t = int'(cfg_oe_len) + 1;
        else                  t = k + (cfg_rdy_early ? 2 : 1);
        e.tag   = tag;
        e.rd    = rd;
        e.rdata = pat(a) & wmask();
        e.strb  = t;
        e.adv   = int'(cfg_adv_len) + 1;
        e.mux   = cfg_mux ? int'(cfg_mux_len) + 1 : 0;
        e.cs    = (al + 1) + t + int'(cfg_hold_len) + 1;
        e.lat   = int'(cfg_setup_len) + 1 + e.cs;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_write = !rd; req_addr = a; req_wdata = d;
        @(negedge clk);
        e.start = cyc;
        m_cs = 0; m_adv = 0; m_strb = 0; m_we = 0; m_mux = 0; m_bad = 0; m_wrongcs = 0;
        m_addr = a; m_wdata = d;
        q.push_back(e);
        inflight = 1;
        req_valid = 0;
        chk("R1 ready low when busy", 64'(req_ready), 64'd0);
        if (poke) begin
            req_valid = 1; req_write = rd; req_addr = a ^ 24'h00F0F0; req_wdata = ~d;
            repeat (2) @(negedge clk);
            req_valid = 0;
        end
        wait (!inflight);
    endtask

    task automatic defaults();
        cfg_wide = 0; cfg_mux = 0; cfg_wait_en = 0; cfg_rdy_early = 0;
        cfg_rdy_hi = 0; cfg_adv_hi = 0; cfg_strb_hi = 0; cfg_cs_hi = 0; cfg_cs_sel = 0;
        cfg_setup_len = 4; cfg_adv_len = 1; cfg_mux_len = 1; cfg_we_len = 1;
        cfg_hold_len = 1; cfg_oe_len = 1; cfg_wait_len = 3; dev_delay = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog R12 actual=hung expected=done");
        finish_run();
    end

    initial begin
        defaults();
        rst = 1; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R13 ready", 64'(req_ready), 64'd1);
        chk("R13 done", 64'(rsp_done), 64'd0);
        chk("R13 doe", 64'(bus_doe), 64'd0);
        chk("R13 controls", 64'({bus_cs, bus_adv, bus_we, bus_oe}), 64'({NCS+3{1'b1}}));

        xfer("R4", 0, 24'h12_3456, 32'hCAFE_F00D, 0);
        cfg_wide = 1; cfg_oe_len = 3;
        xfer("R5", 1, 24'h00_0A10, 32'h0, 1);
        cfg_wide = 0;
        xfer("R11", 1, 24'hAB_CDEF, 32'h0, 0);
        cfg_wide = 1;
        xfer("R11", 0, 24'h00_0001, 32'h8765_4321, 0);
        cfg_mux = 1; cfg_mux_len = 5; cfg_adv_len = 2;
        xfer("R3", 0, 24'h55_AA55, 32'h1357_9BDF, 0);
        cfg_mux_len = 1; cfg_adv_len = 6;
        xfer("R3", 1, 24'h0F_00F0, 32'h0, 0);
        cfg_mux = 0; cfg_adv_len = 1;
        cfg_wait_en = 1; cfg_wait_len = 2; dev_delay = 5;
        xfer("R7", 1, 24'h11_2233, 32'h0, 0);
        cfg_wait_len = 4; dev_delay = 1;
        xfer("R7", 1, 24'h44_5566, 32'h0, 0);
        cfg_rdy_early = 1; cfg_wait_len = 3; dev_delay = 1;
        xfer("R8", 1, 24'h77_8899, 32'h0, 0);
        cfg_wait_len = 0; dev_delay = 4;
        xfer("R8", 1, 24'h9A_BCDE, 32'h0, 0);
        cfg_wait_en = 0; cfg_rdy_early = 0; dev_delay = 0;
        cfg_rdy_hi = 1; cfg_adv_hi = 1; cfg_strb_hi = 1; cfg_cs_hi = 1; cfg_cs_sel = 7;
        xfer("R9", 1, 24'h33_4455, 32'h0, 0);
        cfg_wait_en = 1; cfg_wait_len = 1; dev_delay = 2;
        xfer("R9", 1, 24'h66_7788, 32'h0, 0);
        cfg_wait_en = 0; cfg_cs_sel = 3;
        xfer("R10", 0, 24'h22_1100, 32'hA5A5_5A5A, 0);
        defaults();
        cfg_wide = 1;
        cfg_setup_len = 0; cfg_adv_len = 0; cfg_mux_len = 0; cfg_we_len = 0;
        cfg_hold_len = 0; cfg_oe_len = 0;
        xfer("R2", 0, 24'h01_0203, 32'h0405_0607, 0);
        xfer("R2", 1, 24'h08_090A, 32'h0, 0);
        cfg_setup_len = 15; cfg_adv_len = 15; cfg_we_len = 15; cfg_hold_len = 15;
        cfg_oe_len = 255;
        xfer("R6", 0, 24'hFE_DCBA, 32'hFFFF_0000, 0);
        xfer("R6", 1, 24'hFF_FFFF, 32'h0, 0);
        xfer("R12", 0, 24'h10_2030, 32'h0BAD_F00D, 0);
        @(negedge clk);
        chk("R12 rdata held after write", 64'(rsp_rdata), 64'(pat(24'hFF_FFFF)));
        finish_run();
    end

endmodule